// File: doc/BRIEF.md
# RMII Dibit Datapath Adapter

This block sits on the MAC side of one 10/100 PHY port. It moves data between the 2-bit reduced media independent interface and byte-wide internal streams in both directions. A single 50 MHz reference clock drives the transmit and the receive paths. A speed input selects the rate. At 100 Mb/s a dibit moves on every clock. At 10 Mb/s a dibit moves only on a "slot" clock, which comes once in every ten.

On transmit, the block collects dibits while the enable is high and hands out a whole byte with a one-cycle valid strobe. It also gives a frame-active flag. On receive, it accepts a byte with an error flag whenever it has nothing left to send. It then serialises the byte as four dibits. It drives a combined carrier / data-valid output and a receive-error output.

Top module: `rmii_dibit_adapter`

## Requirements
- R1: At 100 Mb/s (speed10 = 0), txdIn is sampled on every clock edge while txEnIn is high. Take the four sampled dibits d0, d1, d2, d3, in that order. They give txByte = {d3, d2, d1, d0}, so the least significant pair comes first. txByteValid is high for exactly one clock, in the cycle after the edge that samples d3.
- R2: At 10 Mb/s (speed10 = 1), a slot edge occurs on the first clock edge after speed10 rises and then on every tenth edge. txdIn and txEnIn are sampled only on slot edges. Values that txdIn takes between slot edges have no effect on txByte.
- R3: If txEnIn is low on a slot edge before four dibits are collected, the partial byte is discarded. The next high slot starts a new byte at d0.
- R4: txFrameActive equals txEnIn as sampled on the most recent slot edge.
- R5: rxByteReady is high in a cycle whose next edge is a slot edge and in which no dibit of an earlier byte remains to be sent. When rxByteValid is high in such a cycle, rxByteIn is taken. rxdOut then shows bits [1:0], [3:2], [5:4], [7:6] of that byte, one per slot, starting on that edge.
- R6: At 10 Mb/s, rxdOut, rxErOut and crsDvOut change only on slot edges. Each dibit is therefore held for ten clocks.
- R7: While rxCarrier is high on a slot edge, crsDvOut is 1 after that edge.
- R8: rxErOut is 1 while a dibit of a byte taken with rxByteErr = 1 is on rxdOut. It is 0 otherwise.
- R9: Suppose rxCarrier is low on a slot edge and a dibit is still to be sent. Then crsDvOut alternates from slot to slot, starting at 0 on the first such slot. On a slot with no data left, crsDvOut is 0, rxdOut is 2'b00 and rxErOut is 0.
- R10: During and straight after reset, txByteValid, txFrameActive, rxdOut, crsDvOut and rxErOut are 0. At 100 Mb/s with reset released, rxByteReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock, shared by both paths |
| rstN | input | 1 | Active-low synchronous reset |
| speed10 | input | 1 | 1 = 10 Mb/s (one slot per ten clocks), 0 = 100 Mb/s |
| txEnIn | input | 1 | Transmit enable from the MAC |
| txdIn | input | 2 | Transmit dibit from the MAC |
| txByte | output | 8 | Assembled transmit byte |
| txByteValid | output | 1 | One-cycle strobe: txByte is new |
| txFrameActive | output | 1 | Transmit enable as sampled on the last slot |
| rxByteIn | input | 8 | Receive byte to serialise |
| rxByteValid | input | 1 | rxByteIn is present |
| rxByteErr | input | 1 | rxByteIn carries an error |
| rxCarrier | input | 1 | Carrier present on the line |
| rxByteReady | output | 1 | The byte offered is taken on the next edge |
| rxdOut | output | 2 | Receive dibit toward the MAC |
| crsDvOut | output | 1 | Combined carrier sense / data valid |
| rxErOut | output | 1 | Receive error toward the MAC |

## Verification
Both directions run from one shared slot strobe. At 10 Mb/s, a transmit byte can complete on the same slot edge that moves the last dibit of a receive byte onto rxdOut.

The bench provokes this case by starting a transmit frame and a receive byte on the same slot. The fourth slot is then shared by both paths. On the clock after that slot, the bench compares the new byte on txByte and the final dibit on rxdOut with their expected values in the same sample.

Just before the next slot, it checks that the transmit strobe has dropped and that the receive dibit has not moved. The garbage driven on txdIn between slots must leave the transmit byte unchanged.

// File: rtl/rmii_adapter_pkg.sv
package rmii_adapter_pkg;

  // Strobes the control module hands to the datapath for one clock.
  typedef struct packed {
    logic slot;       // dibit slot edge (every clock at 100M, 1 in N at 10M)
    logic txShift;    // capture txdIn into the assembly register
    logic txEmit;     // capture completes a byte
    logic rxLoad;     // take rxByteIn and drive its first dibit
    logic rxAdvance;  // drive the next buffered dibit
    logic rxIdle;     // nothing to send on this slot
    logic crsDvNext;  // value for the combined carrier/valid pin
  } strobe_t;

endpackage

// File: rtl/rmii_adapter_ctrl.sv
module rmii_adapter_ctrl
  import rmii_adapter_pkg::*;
#(
  parameter int SLOW_DIV = 10,
  parameter int DIBITS   = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    speed10,
  input  logic    txEnIn,
  input  logic    rxByteValid,
  input  logic    rxCarrier,
  output strobe_t strb,
  output logic    rxByteReady
);

  localparam int DIV_W  = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int TXC_W  = (DIBITS > 1) ? $clog2(DIBITS) : 1;
  localparam int LEFT_W = $clog2(DIBITS + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(SLOW_DIV - 1);
  localparam logic [TXC_W-1:0]  TX_LAST  = TXC_W'(DIBITS - 1);
  localparam logic [LEFT_W-1:0] RX_FULL  = LEFT_W'(DIBITS - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [TXC_W-1:0]  txCnt;
  logic [LEFT_W-1:0] rxLeft;
  logic              drainPhase;
  logic              slot;
  logic              rxPending;

  assign slot      = !speed10 || (divCnt == '0);
  assign rxPending = (rxLeft != '0) || rxByteValid;
  assign rxByteReady = slot && (rxLeft == '0);

  // Slot divider: held at zero at full speed so 10M starts with a slot.
  always_ff @(posedge clk) begin
    if (!rstN || !speed10) divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else divCnt <= divCnt + DIV_W'(1);
  end

  // Transmit dibit counter; a low enable on a slot drops the partial byte.
  always_ff @(posedge clk) begin
    if (!rstN) txCnt <= '0;
    else if (slot) begin
      if (!txEnIn) txCnt <= '0;
      else if (txCnt == TX_LAST) txCnt <= '0;
      else txCnt <= txCnt + TXC_W'(1);
    end
  end

  // Receive dibits still to be sent after the one currently driven.
  always_ff @(posedge clk) begin
    if (!rstN) rxLeft <= '0;
    else if (slot) begin
      if (rxLeft != '0) rxLeft <= rxLeft - LEFT_W'(1);
      else if (rxByteValid) rxLeft <= RX_FULL;
    end
  end

  // Alternating phase used while draining after carrier loss.
  always_ff @(posedge clk) begin
    if (!rstN) drainPhase <= 1'b0;
    else if (slot) begin
      if (rxCarrier || !rxPending) drainPhase <= 1'b0;
      else drainPhase <= !drainPhase;
    end
  end

  always_comb begin
    strb           = '0;
    strb.slot      = slot;
    strb.txShift   = slot && txEnIn;
    strb.txEmit    = slot && txEnIn && (txCnt == TX_LAST);
    strb.rxAdvance = slot && (rxLeft != '0);
    strb.rxLoad    = slot && (rxLeft == '0) && rxByteValid;
    strb.rxIdle    = slot && !rxPending;
    strb.crsDvNext = rxCarrier ? 1'b1 : (rxPending ? drainPhase : 1'b0);
  end

endmodule

// File: rtl/rmii_adapter_dp.sv
module rmii_adapter_dp
  import rmii_adapter_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              txEnIn,
  input  logic [1:0]        txdIn,
  input  logic [BYTE_W-1:0] rxByteIn,
  input  logic              rxByteErr,
  output logic [BYTE_W-1:0] txByte,
  output logic              txByteValid,
  output logic              txFrameActive,
  output logic [1:0]        rxdOut,
  output logic              crsDvOut,
  output logic              rxErOut
);

  localparam int HOLD_W = BYTE_W - 2;

  logic [HOLD_W-1:0] txHold;
  logic [HOLD_W-1:0] rxHold;
  logic              rxErrHeld;

  // Transmit: new dibits enter at the top, so the first one ends up lowest.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold        <= '0;
      txByte        <= '0;
      txByteValid   <= 1'b0;
      txFrameActive <= 1'b0;
    end else begin
      txByteValid <= strb.txEmit;
      if (strb.txShift) txHold <= {txdIn, txHold[HOLD_W-1:2]};
      if (strb.txEmit)  txByte <= {txdIn, txHold};
      if (strb.slot)    txFrameActive <= txEnIn;
    end
  end

  // Receive: lowest pair goes out first, the rest waits in rxHold.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold    <= '0;
      rxErrHeld <= 1'b0;
      rxdOut    <= 2'b00;
      rxErOut   <= 1'b0;
      crsDvOut  <= 1'b0;
    end else begin
      if (strb.rxLoad) begin
        rxdOut    <= rxByteIn[1:0];
        rxHold    <= rxByteIn[BYTE_W-1:2];
        rxErrHeld <= rxByteErr;
        rxErOut   <= rxByteErr;
      end else if (strb.rxAdvance) begin
        rxdOut  <= rxHold[1:0];
        rxHold  <= {2'b00, rxHold[HOLD_W-1:2]};
        rxErOut <= rxErrHeld;
      end else if (strb.rxIdle) begin
        rxdOut  <= 2'b00;
        rxErOut <= 1'b0;
      end
      if (strb.slot) crsDvOut <= strb.crsDvNext;
    end
  end

endmodule

// File: rtl/rmii_dibit_adapter.sv
module rmii_dibit_adapter
  import rmii_adapter_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SLOW_DIV = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              speed10,
  input  logic              txEnIn,
  input  logic [1:0]        txdIn,
  output logic [BYTE_W-1:0] txByte,
  output logic              txByteValid,
  output logic              txFrameActive,
  input  logic [BYTE_W-1:0] rxByteIn,
  input  logic              rxByteValid,
  input  logic              rxByteErr,
  input  logic              rxCarrier,
  output logic              rxByteReady,
  output logic [1:0]        rxdOut,
  output logic              crsDvOut,
  output logic              rxErOut
);

  localparam int DIBITS = BYTE_W / 2;

  strobe_t strb;

  rmii_adapter_ctrl #(.SLOW_DIV(SLOW_DIV), .DIBITS(DIBITS)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .speed10    (speed10),
    .txEnIn     (txEnIn),
    .rxByteValid(rxByteValid),
    .rxCarrier  (rxCarrier),
    .strb       (strb),
    .rxByteReady(rxByteReady)
  );

  rmii_adapter_dp #(.BYTE_W(BYTE_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .txEnIn       (txEnIn),
    .txdIn        (txdIn),
    .rxByteIn     (rxByteIn),
    .rxByteErr    (rxByteErr),
    .txByte       (txByte),
    .txByteValid  (txByteValid),
    .txFrameActive(txFrameActive),
    .rxdOut       (rxdOut),
    .crsDvOut     (crsDvOut),
    .rxErOut      (rxErOut)
  );

endmodule

// File: rtl/rmii_adapter_checker.sv
module rmii_adapter_checker
  import rmii_adapter_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       rxCarrier,
  input strobe_t    strb,
  input logic [1:0] rxdOut,
  input logic       rxErOut,
  input logic       crsDvOut,
  input logic       txByteValid,
  input logic       txFrameActive
);

  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    txByteValid |=> !txByteValid); // R1

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.slot |=> ($stable(rxdOut) && $stable(rxErOut) && $stable(crsDvOut))); // R6

  AST_TX_FRAME_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    txByteValid |-> txFrameActive); // R4

  AST_CARRIER_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slot && rxCarrier) |=> crsDvOut); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxIdle |=> (rxdOut == 2'b00 && !rxErOut)); // R9

endmodule

bind rmii_dibit_adapter rmii_adapter_checker i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rxCarrier    (rxCarrier),
  .strb         (strb),
  .rxdOut       (rxdOut),
  .rxErOut      (rxErOut),
  .crsDvOut     (crsDvOut),
  .txByteValid  (txByteValid),
  .txFrameActive(txFrameActive)
);

// File: tb/test_rmii_dibit_adapter.sv
`timescale 1ns/1ps
module test_rmii_dibit_adapter;

  logic       clk = 1'b0;
  logic       rstN;
  logic       speed10;
  logic       txEnIn;
  logic [1:0] txdIn;
  logic [7:0] txByte;
  logic       txByteValid;
  logic       txFrameActive;
  logic [7:0] rxByteIn;
  logic       rxByteValid;
  logic       rxByteErr;
  logic       rxCarrier;
  logic       rxByteReady;
  logic [1:0] rxdOut;
  logic       crsDvOut;
  logic       rxErOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = !clk;

  rmii_dibit_adapter i_rmii_dibit_adapter (
    .clk(clk), .rstN(rstN), .speed10(speed10),
    .txEnIn(txEnIn), .txdIn(txdIn),
    .txByte(txByte), .txByteValid(txByteValid), .txFrameActive(txFrameActive),
    .rxByteIn(rxByteIn), .rxByteValid(rxByteValid), .rxByteErr(rxByteErr),
    .rxCarrier(rxCarrier), .rxByteReady(rxByteReady),
    .rxdOut(rxdOut), .crsDvOut(crsDvOut), .rxErOut(rxErOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // {txEn, txd[1:0], expected valid, expected frame active, expected byte}
  localparam int NVEC = 11;
  localparam logic [12:0] TXVEC [NVEC] = '{
    {1'b1, 2'b01, 1'b0, 1'b1, 8'h00},
    {1'b1, 2'b10, 1'b0, 1'b1, 8'h00},
    {1'b1, 2'b11, 1'b0, 1'b1, 8'h00},
    {1'b1, 2'b00, 1'b1, 1'b1, 8'h39},
    {1'b1, 2'b11, 1'b0, 1'b1, 8'h00},
    {1'b0, 2'b10, 1'b0, 1'b0, 8'h00},
    {1'b1, 2'b10, 1'b0, 1'b1, 8'h00},
    {1'b1, 2'b01, 1'b0, 1'b1, 8'h00},
    {1'b1, 2'b00, 1'b0, 1'b1, 8'h00},
    {1'b1, 2'b11, 1'b1, 1'b1, 8'hC6},
    {1'b0, 2'b00, 1'b0, 1'b0, 8'h00}
  };

  // One receive byte at full speed, checked dibit by dibit (R5, R8, R7)
  task automatic rxByte100(input logic [7:0] b, input logic e);
    rxByteIn = b; rxByteValid = 1'b1; rxByteErr = e; rxCarrier = 1'b1;
    checkEq("R5 ready", rxByteReady, 1);
    @(negedge clk);
    rxByteValid = 1'b0;
    for (int j = 0; j < 4; j++) begin
      checkEq("R5 rxd", rxdOut, b[2*j +: 2]);
      checkEq("R8 rxEr", rxErOut, e);
      checkEq("R7 crsDv", crsDvOut, 1);
      @(negedge clk);
    end
    checkEq("R9 idle rxd", rxdOut, 0);
    checkEq("R8 rxEr idle", rxErOut, 0);
    checkEq("R7 crsDv carrier", crsDvOut, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; speed10 = 1'b0; txEnIn = 1'b0; txdIn = 2'b00;
    rxByteIn = 8'h00; rxByteValid = 1'b0; rxByteErr = 1'b0; rxCarrier = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    checkEq("R10 txValid", txByteValid, 0);
    checkEq("R10 txActive", txFrameActive, 0);
    checkEq("R10 rxd", rxdOut, 0);
    checkEq("R10 crsDv", crsDvOut, 0);
    checkEq("R10 rxEr", rxErOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R10 txValid after", txByteValid, 0);
    checkEq("R10 crsDv after", crsDvOut, 0);
    checkEq("R10 ready", rxByteReady, 1);

    // R1 R3 R4: transmit vector walk at full speed
    for (int v = 0; v < NVEC; v++) begin
      txEnIn = TXVEC[v][12];
      txdIn  = TXVEC[v][11:10];
      @(negedge clk);
      checkEq("R1 txValid", txByteValid, TXVEC[v][9]);
      checkEq("R4 txActive", txFrameActive, TXVEC[v][8]);
      if (TXVEC[v][9]) checkEq("R1 R3 txByte", txByte, TXVEC[v][7:0]);
    end

    // R5 R8: receive bytes at full speed
    rxByte100(8'hB4, 1'b0);
    rxByte100(8'h1B, 1'b1);

    // R9: carrier drops while a byte is buffered
    rxCarrier = 1'b0; rxByteIn = 8'hE4; rxByteValid = 1'b1; rxByteErr = 1'b0;
    @(negedge clk);
    rxByteValid = 1'b0;
    for (int j = 0; j < 4; j++) begin
      checkEq("R9 drain rxd", rxdOut, (8'hE4 >> (2*j)) & 3);
      checkEq("R9 drain crsDv", crsDvOut, j % 2);
      @(negedge clk);
    end
    checkEq("R9 drained crsDv", crsDvOut, 0);
    checkEq("R9 drained rxd", rxdOut, 0);

    // R2 R6: 10 Mb/s, transmit and receive share every slot
    begin
      logic [1:0] txSeq [4];
      txSeq[0] = 2'b10; txSeq[1] = 2'b01; txSeq[2] = 2'b11; txSeq[3] = 2'b00;
      speed10 = 1'b1; txEnIn = 1'b1; rxCarrier = 1'b1;
      rxByteIn = 8'h6C; rxByteValid = 1'b1; rxByteErr = 1'b0;
      for (int i = 0; i < 4; i++) begin
        txdIn = txSeq[i];
        @(negedge clk);
        rxByteValid = 1'b0;
        checkEq("R6 rxd slot", rxdOut, (8'h6C >> (2*i)) & 3);
        checkEq("R2 txValid", txByteValid, (i == 3) ? 1 : 0);
        if (i == 3) checkEq("R2 txByte", txByte, 8'h36);
        txdIn = ~txSeq[i];
        repeat (9) @(negedge clk);
        checkEq("R6 rxd held", rxdOut, (8'h6C >> (2*i)) & 3);
        checkEq("R6 crsDv held", crsDvOut, 1);
        checkEq("R2 txValid pulse", txByteValid, 0);
      end
      checkEq("R2 txByte kept", txByte, 8'h36);
      checkEq("R4 txActive slow", txFrameActive, 1);
      txEnIn = 1'b0;
      @(negedge clk);
      checkEq("R6 idle rxd", rxdOut, 0);
      checkEq("R4 txActive dropped", txFrameActive, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule